// File: doc/BRIEF.md
# Handshaked SPI Word Master

This block is a single-target SPI master that moves one word at a time. A producer offers a word on a valid/ready port. The master drops its chip-select and waits out a programmable setup gap. It then runs the serial clock for one word, shifting MOSI out MSB first and collecting MISO into a received word. After a programmable release gap it raises chip-select again. Polarity and phase are selected independently, so all four clocking modes are available. The serial clock half-period is a whole number of system clocks set by a divider input.

The block can also use a slave-ready pin, which is active low. When this handshake is switched on, the first serial clock edge of every word is held back until the slave pulls the pin low. The pin passes through a two-flop synchroniser before it is used. This lets a slow slave stall the master between words. A hold option keeps chip-select low across back-to-back words when the next word is already offered at the end of the release gap.

Back-pressure rules: `tx_data` must stay stable while `tx_valid` is high and not yet accepted. A word is accepted on the rising clock edge where `tx_valid` and `tx_ready` are both high. The received-word port has no ready: `rx_valid` is a one-cycle pulse, and the consumer must take `rx_data` in that cycle. The configuration inputs must be changed only while `busy` is low.

Top module: `spi_hs_master`

## Requirements
- R1: After reset `cs_n` is 1, `busy` is 0, `tx_ready` is 1, `rx_valid` is 0 and `sclk` equals `cpol`.
- R2: `tx_ready` is high only when the master is idle, or in the single handoff cycle at the end of the release gap when `cs_hold` is 1. It is low while a word is being set up or shifted.
- R3: `sclk` rests at the `cpol` level whenever chip-select is high. Each word makes exactly 2*W `sclk` transitions. Consecutive transitions within a word are `clk_div`+1 system clocks apart.
- R4: MOSI carries the word MSB first. With `cpha`=0 the MSB is present from the fall of `cs_n` and the next bit follows each trailing edge. With `cpha`=1 each bit is driven on a leading edge. A slave sampling on the other edge receives `tx_data` unchanged.
- R5: MISO is sampled on leading edges when `cpha`=0 and on trailing edges when `cpha`=1. The first sampled bit becomes bit W-1 of `rx_data`. `rx_valid` pulses for one cycle, visible right after the clock that makes the final `sclk` edge.
- R6: With the handshake off, or with `ena_n` already low, the first `sclk` edge comes exactly `setup_dly`+2 system clocks after `cs_n` falls.
- R7: When no word is handed over, `cs_n` rises exactly `hold_dly`+1 system clocks after the final `sclk` edge of a word.
- R8: With `ena_en`=1, no `sclk` edge is made while the synchronised `ena_n` is high. Once `ena_n` goes low and the setup gap has elapsed, the first edge appears on the third rising clock after the change. This applies to held words too.
- R9: With `ena_en`=0, `ena_n` has no effect on any output.
- R10: With `cs_hold`=1 and `tx_valid` high when the release gap ends, the next word is accepted in that cycle and `cs_n` stays low. Its first edge then comes `hold_dly`+`setup_dly`+3 clocks after the previous final edge. With `cs_hold`=0, `cs_n` rises between every pair of words.
- R11: `busy` is high exactly while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Word offered for transmission |
| tx_ready | output | 1 | Master accepts a word this cycle |
| tx_data | input | W | Word to transmit, MSB first |
| rx_valid | output | 1 | One-cycle pulse: received word present |
| rx_data | output | W | Received word |
| busy | output | 1 | Transfer in progress (chip-select low) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| setup_dly | input | DLY_W | Extra clocks from chip-select fall to first edge |
| hold_dly | input | DLY_W | Extra clocks from final edge to chip-select rise |
| cs_hold | input | 1 | Keep chip-select low for a word waiting at the end of a word |
| ena_en | input | 1 | Use the slave-ready handshake |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip-select, active low |
| ena_n | input | 1 | Slave ready, active low, asynchronous |

## Verification
The hardest case to reach is a stall in the middle of a held burst. Chip-select must stay low across the word handoff while the slave has withdrawn ready, so the second word must be offered before the release gap ends. The ready pin must then rise after the final edge of the first word but before the synchroniser output reaches the setup logic. The bench starts from a directed sequence that watches for the final edge of the first word. It raises the pin at once and offers the next word, then checks that no edge appears and chip-select never rises. When it releases the pin, it checks that the first edge lands exactly three clocks later. Randomised words with noise on the ignored ready pin cover the four modes and the range of divider and delay values.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_POST  = 2'd3
  } spi_hs_state_e;
endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hs_ctrl.sv
module spi_hs_ctrl
  import spi_hs_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic             cs_hold,
  input  logic             ena_en,
  input  logic             ena_act,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [DLY_W-1:0] setup_dly,
  input  logic [DLY_W-1:0] hold_dly,
  output logic             tx_ready,
  output logic             load,
  output logic             tick,
  output logic             lead,
  output logic             last,
  output logic             ph,
  output logic             cs_n,
  output logic             busy
);
  localparam int EDGES = 2 * W;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam int CNT_W = DLY_W + 1;

  spi_hs_state_e    st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] hcnt;
  logic [EC_W-1:0]  ecnt;
  logic             go;
  logic [CNT_W-1:0] setup_ld;
  logic [CNT_W-1:0] hold_ld;

  assign go       = !ena_en || ena_act;
  assign setup_ld = {1'b0, setup_dly} + CNT_W'(1);
  assign hold_ld  = {1'b0, hold_dly};
  assign tx_ready = (st == ST_IDLE) || (st == ST_POST && cnt == '0 && cs_hold);
  assign load     = tx_valid && tx_ready;
  assign tick     = (st == ST_SETUP && cnt == '0 && go) ||
                    (st == ST_SHIFT && hcnt == '0);
  assign lead     = ~ecnt[0];
  assign last     = tick && (ecnt == EC_W'(EDGES - 1));
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      hcnt <= '0;
      ecnt <= '0;
      ph   <= 1'b0;
      cs_n <= 1'b1;
    end else if (tick) begin
      ph   <= ~ph;
      ecnt <= ecnt + EC_W'(1);
      hcnt <= clk_div;
      if (last) begin
        st  <= ST_POST;
        cnt <= hold_ld;
      end else begin
        st  <= ST_SHIFT;
      end
    end else begin
      case (st)
        ST_IDLE: begin
          if (load) begin
            st   <= ST_SETUP;
            cnt  <= setup_ld;
            ecnt <= '0;
            cs_n <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
        end
        ST_SHIFT: begin
          hcnt <= hcnt - DIV_W'(1);
        end
        ST_POST: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (load) begin
            st   <= ST_SETUP;
            cnt  <= setup_ld;
            ecnt <= '0;
          end else begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_cs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !ph);
  p_word_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ecnt == EC_W'(EDGES));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP && ena_en && !ena_act) |=> $stable(ph));
  p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POST && load) |=> !cs_n);
  p_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT || st == ST_SETUP) |-> !tx_ready);
endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpha,
  input  logic         load,
  input  logic [W-1:0] tx_data,
  input  logic         tick,
  input  logic         lead,
  input  logic         last,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  logic [W-1:0] txsh;
  logic [W-1:0] rxsh;
  logic         drv;
  logic         samp;

  assign drv  = tick && (lead == cpha);
  assign samp = tick && (lead != cpha);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh     <= '0;
      rxsh     <= '0;
      mosi     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last;
      if (load) begin
        if (cpha) begin
          mosi <= 1'b0;
          txsh <= tx_data;
        end else begin
          mosi <= tx_data[W-1];
          txsh <= {tx_data[W-2:0], 1'b0};
        end
      end else if (drv) begin
        mosi <= txsh[W-1];
        txsh <= {txsh[W-2:0], 1'b0};
      end
      if (samp) rxsh <= {rxsh[W-2:0], miso};
      if (last) rx_data <= cpha ? {rxsh[W-2:0], miso} : rxsh;
    end
  end

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master #(
  parameter int W     = 8,
  parameter int DIV_W = 8,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_data,
  output logic             rx_valid,
  output logic [W-1:0]     rx_data,
  output logic             busy,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [DLY_W-1:0] setup_dly,
  input  logic [DLY_W-1:0] hold_dly,
  input  logic             cs_hold,
  input  logic             ena_en,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  input  logic             ena_n
);
  logic ena_q;
  logic load;
  logic tick;
  logic lead;
  logic last;
  logic ph;

  spi_hs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ena_n),
    .q     (ena_q)
  );

  spi_hs_ctrl #(.W(W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .cs_hold   (cs_hold),
    .ena_en    (ena_en),
    .ena_act   (~ena_q),
    .clk_div   (clk_div),
    .setup_dly (setup_dly),
    .hold_dly  (hold_dly),
    .tx_ready  (tx_ready),
    .load      (load),
    .tick      (tick),
    .lead      (lead),
    .last      (last),
    .ph        (ph),
    .cs_n      (cs_n),
    .busy      (busy)
  );

  spi_hs_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpha     (cpha),
    .load     (load),
    .tx_data  (tx_data),
    .tick     (tick),
    .lead     (lead),
    .last     (last),
    .miso     (miso),
    .mosi     (mosi),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  assign sclk = cpol ^ ph;
endmodule

// File: tb/spi_hs_master_tb.sv
module spi_hs_master_tb;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       busy;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic [7:0] clk_div = '0;
  logic [4:0] setup_dly = '0, hold_dly = '0;
  logic       cs_hold = 1'b0, ena_en = 1'b0;
  logic       sclk, mosi, cs_n;
  logic       miso = 1'b0;
  logic       ena_drv = 1'b1, noise_on = 1'b0, noise_bit = 1'b1;
  logic       ena_pin;

  assign ena_pin = noise_on ? noise_bit : ena_drv;

  always #5 clk = ~clk;

  spi_hs_master u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .cpol(cpol), .cpha(cpha), .clk_div(clk_div), .setup_dly(setup_dly),
    .hold_dly(hold_dly), .cs_hold(cs_hold), .ena_en(ena_en), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .ena_n(ena_pin)
  );

  int n_chk = 0, n_err = 0, wdog = 0;

  // slave model and timing monitor, evaluated on falling clock edges
  int         cyc = 0, ecount = 0, wd = 0, rx_n = 0, rise_cnt = 0;
  int         t_ref = 0, t_edge = 0, t_fin = 0, rel_gap = 0, ecnt_rise = 0;
  int         wgap [0:255];
  int         wfirst [0:255];
  int         whp [0:255];
  logic [7:0] wslv [0:255];
  logic [7:0] rxlog [0:255];
  logic [7:0] slv_tx = '0, slv_sh = '0, slv_rx = '0;
  logic       prev_cs = 1'b1, prev_sclk = 1'b0, edge_lead;
  int         bsy_err = 0;

  task automatic slv_load();
    slv_sh = slv_tx;
    slv_rx = '0;
    if (!cpha) begin
      miso   = slv_sh[7];
      slv_sh = {slv_sh[6:0], 1'b0};
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    noise_bit <= 1'($urandom % 2);
    if (!rst_n) begin
      prev_cs = cs_n;
      prev_sclk = sclk;
    end else begin
      if (busy == cs_n) bsy_err++;
      if (prev_cs && !cs_n) begin
        t_ref = cyc;
        ecount = 0;
        slv_load();
      end
      if (sclk != prev_sclk && !cs_n) begin
        ecount++;
        edge_lead = ecount[0];
        if (ecount == 1) begin
          wgap[wd] = cyc - t_ref;
          wfirst[wd] = cyc;
          whp[wd] = 0;
        end else if (cyc - t_edge != int'(clk_div) + 1) begin
          whp[wd]++;
        end
        t_edge = cyc;
        if (edge_lead ^ cpha) begin
          slv_rx = {slv_rx[6:0], mosi};
        end else begin
          miso   = slv_sh[7];
          slv_sh = {slv_sh[6:0], 1'b0};
        end
        if (ecount == 2 * W) begin
          wslv[wd] = slv_rx;
          wd++;
          ecount = 0;
          t_ref = cyc;
          t_fin = cyc;
          slv_load();
        end
      end
      if (!prev_cs && cs_n) begin
        rel_gap = cyc - t_fin;
        rise_cnt++;
        ecnt_rise = ecount;
      end
      if (rx_valid) begin
        rxlog[rx_n] = rx_data;
        rx_n++;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", wdog);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_setup_gap(input int s);
    return s + 2;
  endfunction
  function automatic int exp_release_gap(input int h);
    return h + 1;
  endfunction
  function automatic int exp_held_gap(input int s, input int h);
    return s + h + 3;
  endfunction

  task automatic push(input logic [7:0] d);
    @(negedge clk); #1;
    tx_valid = 1'b1;
    tx_data  = d;
    forever begin
      if (tx_ready) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle(input int n);
    forever begin
      @(negedge clk); #1;
      if (wd >= n && cs_n) break;
    end
  endtask

  task automatic check_word(input int i, input logic [7:0] t, input logic [7:0] s,
                            input bit gapchk);
    chk("R4 slave received word", int'(wslv[i]), int'(t));
    chk("R5 rx_data word", int'(rxlog[i]), int'(s));
    chk("R5 rx_valid pulse count", rx_n, i + 1);
    chk("R3 half-period mismatches", whp[i], 0);
    chk("R3 edges left at release", ecnt_rise, 0);
    chk("R3 idle sclk level", int'(sclk), int'(cpol));
    if (gapchk) chk("R6 setup gap", wgap[i], exp_setup_gap(int'(setup_dly)));
    chk("R7 release gap", rel_gap, exp_release_gap(int'(hold_dly)));
    chk("R11 busy low after release", int'(busy), 0);
  endtask

  task automatic xfer(input logic [7:0] t, input logic [7:0] s, input bit gapchk);
    int base;
    base = wd;
    slv_tx = s;
    push(t);
    wait_idle(base + 1);
    check_word(base, t, s, gapchk);
  endtask

  task automatic cfg(input logic pol, input logic pha, input int dv,
                     input int su, input int hd);
    @(negedge clk); #1;
    cpol = pol; cpha = pha;
    clk_div = 8'(dv); setup_dly = 5'(su); hold_dly = 5'(hd);
    @(negedge clk); #1;
  endtask

  initial begin
    int base, r0, c;
    logic [7:0] s;
    void'($urandom(32'd20240611));
    cpol = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 cs_n after reset", int'(cs_n), 1);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 tx_ready after reset", int'(tx_ready), 1);
    chk("R1 rx_valid after reset", int'(rx_valid), 0);
    chk("R1 sclk idle at cpol", int'(sclk), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs_n idle", int'(cs_n), 1);

    // fastest settings in all four modes
    for (int m = 0; m < 4; m++) begin
      cfg(m[1], m[0], 0, 0, 0);
      xfer(8'hA5 ^ 8'(m), 8'h3C + 8'(m), 1'b1);
    end
    // R2: tx_ready low while a word is in flight
    cfg(1'b0, 1'b1, 2, 1, 1);
    slv_tx = 8'h81;
    base = wd;
    push(8'h7E);
    @(negedge clk); #1;
    chk("R2 tx_ready low during word", int'(tx_ready), 0);
    chk("R11 busy high during word", int'(busy), 1);
    wait_idle(base + 1);
    check_word(base, 8'h7E, 8'h81, 1'b1);
    // widest delays
    cfg(1'b1, 1'b0, 3, 31, 31);
    xfer(8'h01, 8'h80, 1'b1);
    cfg(1'b0, 1'b1, 3, 31, 31);
    xfer(8'hFE, 8'h7F, 1'b1);

    // R9: random words, handshake off, noise on the ready pin
    noise_on = 1'b1;
    for (int k = 0; k < 30; k++) begin
      cfg(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 5),
          (k % 7 == 0) ? 31 : int'($urandom % 8), int'($urandom % 8));
      xfer(8'($urandom), 8'($urandom), 1'b1);
    end
    noise_on = 1'b0;

    // R10: held burst of three words
    cfg(1'b0, 1'b0, 1, 2, 3);
    cs_hold = 1'b1;
    base = wd; r0 = rise_cnt; slv_tx = 8'h5A;
    push(8'h11); push(8'h22); push(8'h33);
    wait_idle(base + 3);
    chk("R10 single release over held burst", rise_cnt, r0 + 1);
    chk("R10 held gap word 2", wgap[base + 1], exp_held_gap(2, 3));
    chk("R10 held gap word 3", wgap[base + 2], exp_held_gap(2, 3));
    chk("R4 held word 2", int'(wslv[base + 1]), 8'h22);
    chk("R4 held word 3", int'(wslv[base + 2]), 8'h33);
    chk("R5 held rx word 3", int'(rxlog[base + 2]), 8'h5A);
    chk("R7 release after held burst", rel_gap, exp_release_gap(3));
    // R10: hold off releases chip-select between words
    cs_hold = 1'b0;
    cfg(1'b1, 1'b1, 0, 1, 2);
    base = wd; r0 = rise_cnt; slv_tx = 8'hC3;
    push(8'h44); push(8'h55);
    wait_idle(base + 2);
    chk("R10 release between unheld words", rise_cnt, r0 + 2);
    chk("R6 gap of second unheld word", wgap[base + 1], exp_setup_gap(1));
    chk("R4 unheld word 2", int'(wslv[base + 1]), 8'h55);

    // R8: handshake stall at the start of a word
    cfg(1'b0, 1'b0, 1, 3, 2);
    ena_en = 1'b1; ena_drv = 1'b1;
    base = wd; slv_tx = 8'h96;
    push(8'h69);
    repeat (20) @(negedge clk);
    #1;
    chk("R8 no edge while ready high", ecount, 0);
    chk("R8 chip-select held low while stalled", int'(cs_n), 0);
    ena_drv = 1'b0;
    c = cyc;
    wait_idle(base + 1);
    chk("R8 first edge after ready", wfirst[base], c + 3);
    check_word(base, 8'h69, 8'h96, 1'b0);
    // ready already low: normal setup timing
    cfg(1'b1, 1'b0, 2, 4, 1);
    xfer(8'hB4, 8'h4B, 1'b1);

    // R8 with R10: slave withdraws ready between held words
    cfg(1'b0, 1'b1, 1, 1, 4);
    cs_hold = 1'b1;
    base = wd; r0 = rise_cnt; slv_tx = 8'hE7;
    push(8'h18);
    forever begin
      if (wd >= base + 1) break;
      @(negedge clk); #1;
    end
    ena_drv = 1'b1;
    push(8'h29);
    repeat (15) @(negedge clk);
    #1;
    chk("R8 held word stalled", wd, base + 1);
    chk("R10 chip-select low during stall", int'(cs_n), 0);
    ena_drv = 1'b0;
    c = cyc;
    wait_idle(base + 2);
    chk("R8 held first edge after ready", wfirst[base + 1], c + 3);
    chk("R10 one release for stalled burst", rise_cnt, r0 + 1);
    chk("R4 stalled held word", int'(wslv[base + 1]), 8'h29);
    cs_hold = 1'b0;
    ena_en = 1'b0;

    chk("R11 busy mirrors chip-select", bsy_err, 0);
    s = 8'h00;
    if (s != 8'h00) n_err++;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule